// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a serial control-port slave that lets a host program and read back a small bank of 8-bit configuration registers. It uses four wires: an active-low frame select, a serial clock, host-to-slave data and slave-to-host data. All sampling happens in the block's own system clock domain. The select, serial clock and data-in lines are first passed through synchronizer flops. Edges of the serial clock and of the select line are then found by comparing each synchronized line with its value one cycle earlier.

Every transaction is one 16-bit frame that opens when the select line falls. The frame carries a 7-bit register address (most significant bit first), then a direction flag, then an 8-bit data phase. In a write frame, the data phase is stored into the addressed register. In a read frame, the block shifts the addressed register out on the data-out line during those same 8 clocks and discards whatever the host sends. The register contents are presented in parallel on a flat output bus for use by the rest of the device. Addresses with no register behind them read as zero and ignore writes. Bits marked reserved always hold zero.

Top module: `cfg_spi_slave`

## Requirements
- R1: After reset, every register on `cfg_o` is 0x00, `sdo_oe_o` is low and `sdo_o` is low.
- R2: A frame opens on a falling edge of `sel_ni`. Data-in is sampled on rising `sclk_i` edges. Frame bits 1 to 7 are the register address, MSB first. Bit 8 is the direction flag (0 = write, 1 = read). Bits 9 to 16 are the data phase. Register `a` appears on `cfg_o[8*a+7 : 8*a]`.
- R3: In a write frame to an implemented address, the 8 data-phase bits (MSB first) are stored in the addressed register once the 16th rising edge has been received.
- R4: In a read frame, the addressed register is driven on `sdo_o` MSB first. Each bit changes after a falling `sclk_i` edge, so that the host can sample the bits on rising edges 9 to 16.
- R5: In a read frame, the data-in bits of the data phase are ignored, and no register changes.
- R6: If `sel_ni` rises before the 16th rising edge, the frame is dropped with no register write. The next frame is decoded from its first bit.
- R7: Addresses at or above the number of implemented registers (16 by default, up to 0x7F) read as 0x00, and writes to them change nothing.
- R8: `sdo_oe_o` is high only in a read frame, from the direction bit until the frame completes or is dropped. `sdo_o` is low whenever `sdo_oe_o` is low.
- R9: Reserved bits always hold 0. With the default parameters, these are bits 7:4 of the last register (address 0x0F).
- R10: Serial clock edges while `sel_ni` is high have no effect on the registers or on the decoding of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_ni | input | 1 | Active-low frame select from the host |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial read data to the host |
| sdo_oe_o | output | 1 | Drive enable for `sdo_o` (high during the read data phase) |
| cfg_o | output | NREG*DW | Flat view of all configuration registers, register 0 in the low byte |

## Verification
The hardest situation to create is a frame cut short at the worst moment: the select line rising after 15 data bits, one edge before a write would commit. A read must then confirm that the old register value survived. The driver task therefore takes a bit count as well as address, direction and data. This lets the bench stop a frame after 12 or after 15 bits, follow it with a full read and a full write, and show that both the abort and the counter restart behave correctly. A burst of serial clocks with the select line high, sent before a frame, covers the case of edges arriving outside any frame.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_WDATA = 3'd2,
    PH_RDATA = 3'd3,
    PH_DONE  = 3'd4
  } frm_phase_e;
endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
  parameter int unsigned       W       = 3,
  parameter int unsigned       STAGES  = 2,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame
  import cfg_spi_pkg::*;
#(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8,
  parameter int unsigned CW = $clog2(AW + DW + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_ni,     // synchronized
  input  logic          sclk_i,     // synchronized
  input  logic          sdi_i,      // synchronized
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] addr_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_data_o,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic [CW-1:0] bit_cnt_o,
  output logic          dir_o
);
  localparam int unsigned FRAME = AW + 1 + DW;
  localparam int unsigned SW    = (AW > DW) ? AW : DW;
  localparam int unsigned OW    = $clog2(DW + 1);

  frm_phase_e    phase;
  logic [CW-1:0] cnt;
  logic [SW-1:0] sh;
  logic [AW-1:0] addr_q;
  logic          dir_q;
  logic [DW-1:0] out_sh;
  logic [OW-1:0] out_left;
  logic          sdo_q;
  logic          wr_en_q;
  logic [DW-1:0] wr_data_q;
  logic          sel_q, sclk_q;
  logic          sel_fall, sclk_rise, sclk_fall, in_frame;

  assign sel_fall  = ~sel_ni & sel_q;
  assign sclk_rise = sclk_i & ~sclk_q;
  assign sclk_fall = ~sclk_i & sclk_q;
  assign in_frame  = (phase == PH_ADDR) || (phase == PH_WDATA) || (phase == PH_RDATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      sel_q  <= sel_ni;
      sclk_q <= sclk_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      sh        <= '0;
      addr_q    <= '0;
      dir_q     <= 1'b0;
      out_sh    <= '0;
      out_left  <= '0;
      sdo_q     <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (sel_fall) begin
        phase <= PH_ADDR;
        cnt   <= '0;
        sdo_q <= 1'b0;
        dir_q <= 1'b0;
      end else if (sel_ni) begin
        // frame closed or aborted
        phase <= PH_IDLE;
        cnt   <= '0;
      end else begin
        if (sclk_rise && in_frame) begin
          cnt <= cnt + 1'b1;
          sh  <= {sh[SW-2:0], sdi_i};
          if (phase == PH_ADDR && cnt == CW'(AW)) begin
            addr_q <= sh[AW-1:0];
            dir_q  <= sdi_i;
            if (sdi_i) begin
              phase    <= PH_RDATA;
              out_sh   <= rd_data_i;
              out_left <= OW'(DW);
            end else begin
              phase <= PH_WDATA;
            end
          end else if (cnt == CW'(FRAME - 1)) begin
            if (phase == PH_WDATA) begin
              wr_en_q   <= 1'b1;
              wr_data_q <= {sh[DW-2:0], sdi_i};
            end
            phase <= PH_DONE;
          end
        end
        if (sclk_fall && phase == PH_RDATA && out_left != '0) begin
          sdo_q    <= out_sh[DW-1];
          out_sh   <= {out_sh[DW-2:0], 1'b0};
          out_left <= out_left - 1'b1;
        end
      end
    end
  end

  assign addr_o    = (phase == PH_ADDR) ? sh[AW-1:0] : addr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_data_o = wr_data_q;
  assign sdo_oe_o  = (phase == PH_RDATA);
  assign sdo_o     = sdo_oe_o & sdo_q;
  assign bit_cnt_o = cnt;
  assign dir_o     = dir_q;
endmodule

// File: rtl/cfg_spi_regbank.sv
module cfg_spi_regbank #(
  parameter int unsigned          AW        = 7,
  parameter int unsigned          DW        = 8,
  parameter int unsigned          NREG      = 16,
  parameter logic [NREG*DW-1:0]   RSVD_MASK = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      addr_i,
  input  logic               wr_en_i,
  input  logic [DW-1:0]      wr_data_i,
  output logic [DW-1:0]      rd_data_o,
  output logic [NREG*DW-1:0] cfg_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] KEEP = ~RSVD_MASK[g*DW +: DW];
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_en_i && addr_i == AW'(g)) q <= wr_data_i & KEEP;
    end
    assign cfg_o[g*DW +: DW] = q;
  end

  // unmatched addresses fall through to zero
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr_i == AW'(i)) rd_data_o = cfg_o[i*DW +: DW];
    end
  end
endmodule

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave #(
  parameter int unsigned        AW        = 7,
  parameter int unsigned        DW        = 8,
  parameter int unsigned        NREG      = 16,
  parameter int unsigned        SYNC      = 2,
  parameter logic [NREG*DW-1:0] RSVD_MASK = {{4{1'b1}}, {(NREG*DW-4){1'b0}}}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_ni,
  input  logic               sclk_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  output logic               sdo_oe_o,
  output logic [NREG*DW-1:0] cfg_o
);
  localparam int unsigned CW = $clog2(AW + DW + 2);

  logic [2:0]    line_s;
  logic [AW-1:0] reg_addr;
  logic          reg_wr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic [CW-1:0] frm_cnt;
  logic          frm_dir;

  cfg_spi_sync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sel_ni, sclk_i, sdi_i}),
    .q_o    (line_s)
  );

  cfg_spi_frame #(.AW(AW), .DW(DW), .CW(CW)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_ni    (line_s[2]),
    .sclk_i    (line_s[1]),
    .sdi_i     (line_s[0]),
    .rd_data_i (reg_rdata),
    .addr_o    (reg_addr),
    .wr_en_o   (reg_wr),
    .wr_data_o (reg_wdata),
    .sdo_o     (sdo_o),
    .sdo_oe_o  (sdo_oe_o),
    .bit_cnt_o (frm_cnt),
    .dir_o     (frm_dir)
  );

  cfg_spi_regbank #(.AW(AW), .DW(DW), .NREG(NREG), .RSVD_MASK(RSVD_MASK)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (reg_addr),
    .wr_en_i   (reg_wr),
    .wr_data_i (reg_wdata),
    .rd_data_o (reg_rdata),
    .cfg_o     (cfg_o)
  );
endmodule

// File: rtl/cfg_spi_slave_chk.sv
module cfg_spi_slave_chk #(
  parameter int unsigned        AW        = 7,
  parameter int unsigned        DW        = 8,
  parameter int unsigned        NREG      = 16,
  parameter logic [NREG*DW-1:0] RSVD_MASK = '0,
  parameter int unsigned        CW        = $clog2(AW + DW + 2)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NREG*DW-1:0] cfg_o,
  input logic               sdo_oe_o,
  input logic               reg_wr,
  input logic               frm_dir,
  input logic [CW-1:0]      frm_cnt
);
  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_cnt <= CW'(AW + 1 + DW));

  // R3
  reg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> $past(reg_wr));

  // R5
  no_rd_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr |-> !frm_dir);

  // R8
  oe_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> (frm_cnt == CW'(AW + 1)) && frm_dir);

  // R8
  oe_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> frm_cnt > CW'(AW));

  // R9
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o & RSVD_MASK) == '0);
endmodule

bind cfg_spi_slave cfg_spi_slave_chk #(
  .AW(AW), .DW(DW), .NREG(NREG), .RSVD_MASK(RSVD_MASK), .CW(CW)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_o    (cfg_o),
  .sdo_oe_o (sdo_oe_o),
  .reg_wr   (reg_wr),
  .frm_dir  (frm_dir),
  .frm_cnt  (frm_cnt)
);

// File: tb/cfg_spi_slave_bench.sv
module cfg_spi_slave_bench;
  localparam int NREG = 16;
  localparam int H    = 8;   // system clocks per serial half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [NREG*8-1:0] cfg;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [7:0] exp_reg [128];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  bit         cur_read = 0;
  int         bit_no = 0;

  always #10 clk = ~clk;

  cfg_spi_slave u_cfg_spi_slave (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .sel_ni   (sel_n),
    .sclk_i   (sclk),
    .sdi_i    (sdi),
    .sdo_o    (sdo),
    .sdo_oe_o (sdo_oe),
    .cfg_o    (cfg)
  );

  function automatic logic [7:0] rsvd(input int a);
    return (a == NREG-1) ? 8'hF0 : 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    bit bad = 0;
    n_chk++;
    for (int a = 0; a < NREG; a++) begin
      if (!bad && cfg[a*8 +: 8] !== exp_reg[a]) begin
        bad = 1;
        n_err++;
        $display("FAIL %s: reg %0d got %02h expected %02h", tag, a, cfg[a*8 +: 8], exp_reg[a]);
      end
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one frame of nbits, pushes the expected read byte to the scoreboard
  task automatic xfer(input logic [6:0] a, input logic rd, input logic [7:0] d, input int nbits);
    logic [15:0] fr;
    fr = {a, rd, d};
    if (rd && nbits == 16) begin
      exp_q.push_back(exp_reg[a]);
      tag_q.push_back((a >= NREG) ? "R7" : ((a == NREG-1) ? "R9" : "R4"));
    end
    @(negedge clk);
    cur_read = rd;
    sel_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < nbits; i++) begin
      bit_no = i;
      sdi = fr[15-i];
      wait_clk(H);
      sclk = 1'b1;
      wait_clk(H);
      sclk = 1'b0;
    end
    wait_clk(H);
    sel_n = 1'b1;
    cur_read = 0;
    wait_clk(2*H);
    if (!rd && nbits == 16 && a < NREG) exp_reg[a] = d & ~rsvd(a);
  endtask

  // monitor: collects read bits on rising serial clock and checks the enable
  initial begin
    logic [7:0] got = '0;
    logic [7:0] e;
    string t;
    forever begin
      @(posedge sclk);
      if (!sel_n) begin
        chk("R8 oe", {7'd0, sdo_oe}, {7'd0, (cur_read && bit_no >= 8)});
        if (cur_read && bit_no >= 8) begin
          got = {got[6:0], sdo};
          if (bit_no == 15) begin
            if (exp_q.size() == 0) begin
              n_chk++; n_err++;
              $display("FAIL R4: got %02h expected no read", got);
            end else begin
              e = exp_q.pop_front();
              t = tag_q.pop_front();
              chk(t, got, e);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 128; a++) exp_reg[a] = '0;
    wait_clk(6);
    rst_n = 1'b1;
    wait_clk(4);

    // R1 reset state
    check_all("R1");
    chk("R1 oe", {7'd0, sdo_oe}, 8'd0);
    chk("R1 sdo", {7'd0, sdo}, 8'd0);

    // R10 clocks with select high
    sdi = 1'b1;
    for (int i = 0; i < 5; i++) begin
      wait_clk(H); sclk = 1'b1; wait_clk(H); sclk = 1'b0;
    end
    check_all("R10 idle clocks");
    xfer(7'd2, 1'b0, 8'h96, 16);
    check_all("R10 frame after idle clocks");

    // R3 fill every register, R9 reserved nibble on last one
    for (int a = 0; a < NREG; a++) xfer(7'(a), 1'b0, 8'(a * 8'h11) ^ 8'h5A, 16);
    check_all("R3");
    chk("R9 cfg", cfg[(NREG-1)*8 +: 8], 8'h0F & (8'((NREG-1) * 8'h11) ^ 8'h5A));

    // R2 bit order: addresses 1 and 8 differ only in bit position
    xfer(7'd1, 1'b0, 8'h81, 16);
    xfer(7'd8, 1'b0, 8'h18, 16);
    check_all("R2");

    // R4 reads, R7 unimplemented
    for (int a = 0; a < NREG; a++) xfer(7'(a), 1'b1, 8'h00, 16);
    xfer(7'h10, 1'b1, 8'h00, 16);
    xfer(7'h7F, 1'b1, 8'h00, 16);
    xfer(7'h20, 1'b0, 8'hEE, 16);
    xfer(7'h7F, 1'b0, 8'hFF, 16);
    check_all("R7");
    xfer(7'h20, 1'b1, 8'h00, 16);

    // R5 data-in during read ignored
    xfer(7'd4, 1'b1, 8'hFF, 16);
    xfer(7'd5, 1'b1, 8'hA5, 16);
    check_all("R5");

    // R6 aborts at 12 and 15 bits
    xfer(7'd3, 1'b0, 8'hC3, 12);
    check_all("R6 abort 12");
    xfer(7'd3, 1'b0, 8'h3C, 15);
    check_all("R6 abort 15");
    xfer(7'd6, 1'b1, 8'h00, 11);
    check_all("R6 read abort");
    xfer(7'd3, 1'b1, 8'h00, 16);
    xfer(7'd3, 1'b0, 8'h3C, 16);
    check_all("R6 write after abort");
    xfer(7'd3, 1'b1, 8'h00, 16);

    // R9 write ones to reserved field
    xfer(7'(NREG-1), 1'b0, 8'hFF, 16);
    chk("R9 rsvd", cfg[(NREG-1)*8 +: 8], 8'h0F);
    xfer(7'(NREG-1), 1'b1, 8'h00, 16);

    // R8 idle after frames
    chk("R8 oe idle", {7'd0, sdo_oe}, 8'd0);
    chk("R8 sdo idle", {7'd0, sdo}, 8'd0);
    chk("R4 scoreboard drained", 8'(exp_q.size()), 8'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule